// File: doc/BRIEF.md
# Posted Interrupt Notification Processor

This block takes an external interrupt that is pending at the interrupt controller for a virtualized processor and decides what to do with it. It acknowledges the interrupt and latches the physical vector that comes back. It then compares that vector with a programmable notification vector. A vector that differs is handed back as a VM-exit indication that carries the vector. A vector that matches starts a fixed sequence, one step per cycle:
- clear the notification flag in the descriptor;
- dismiss the interrupt with a zero write to the end-of-interrupt register;
- fold the 256-bit posted-request bitmap into the virtual request register and empty the bitmap;
- raise the requesting-virtual-interrupt index (RVI);
- pulse a request to evaluate pending virtual interrupts.

The descriptor storage sits inside the block. It holds the posted-request bitmap, the notification flag and a small field of other control bits. Devices post requests through a single-index write port, and an auxiliary port writes the control bits. The merge step is atomic against posting. For the one merge cycle a stall flag is raised, and a posting write that arrives in that cycle is parked in a one-entry buffer. The buffered write lands after the bitmap has been cleared, so no request is lost.

Top module: `notify_post_proc`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to idle and clears the virtual request register, RVI, the stall flag, the done and evaluate pulses, the bitmap, the notification flag and the control field.
- R2: In the cycle after the block sees `irq_pend` high while idle, `irq_ack` is high for exactly one cycle, and `irq_vec` is latched on that cycle's closing edge.
- R3: When the latched vector differs from `notif_vec`, `vmexit` is high for one cycle with `exit_vec` equal to the latched vector. No end-of-interrupt write follows, and the bitmap, virtual request register and RVI stay unchanged.
- R4: On a match, the notification flag is cleared and the control field `desc_aux` keeps its value. This behaves as an AND-mask write that touches only the flag.
- R5: After the flag clear, `eoi_wr` is high for exactly one cycle with `eoi_data` equal to zero.
- R6: In the merge step, the virtual request register becomes its old value OR the bitmap, and the bitmap reads all-zero afterwards.
- R7: `post_stall` is high during the merge cycle only. A posting write in that cycle is not merged. It appears in the bitmap, with the flag set, one cycle after the clear.
- R8: RVI becomes the larger of its old value and the highest set bitmap index, where index i is bit i of `desc_pir`. With an empty bitmap RVI keeps its value.
- R9: `eval_pend` is high for one cycle as the last step of the match sequence, and `done` is high for one cycle after the return to idle (after `vmexit` on a mismatch).
- R10: A posting write outside the merge cycle sets bit `post_vec` of the bitmap and the notification flag on the next edge. When it coincides with the flag clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 1 | External interrupt pending at the controller |
| irq_vec | input | 8 | Physical vector returned on acknowledge |
| irq_ack | output | 1 | Acknowledge pulse to the controller |
| notif_vec | input | 8 | Programmed notification vector |
| vmexit | output | 1 | Mismatch: VM-exit indication |
| exit_vec | output | 8 | Vector carried with the exit indication |
| post_we | input | 1 | Posting write strobe |
| post_vec | input | 8 | Bitmap index to set |
| post_stall | output | 1 | Bitmap locked for the merge |
| aux_we | input | 1 | Control-field write strobe |
| aux_wdata | input | 7 | Control-field write data |
| desc_pir | output | 256 | Posted-request bitmap |
| desc_on | output | 1 | Outstanding-notification flag |
| desc_aux | output | 7 | Descriptor control field |
| eoi_wr | output | 1 | End-of-interrupt write strobe |
| eoi_data | output | 32 | End-of-interrupt write data (zero) |
| virr | output | 256 | Virtual request register |
| rvi | output | 8 | Requesting virtual interrupt index |
| eval_pend | output | 1 | Evaluate-pending-virtual-interrupts pulse |
| done | output | 1 | Sequence-complete pulse |

## Verification
The results are due at fixed cycle counts after the edge that first samples `irq_pend` (edge 0):
- `irq_ack` after edge 0;
- `vmexit` and `exit_vec` after edge 1;
- on a mismatch, `done` after edge 2;
- on a match, the cleared flag and the EOI write after edge 3;
- `post_stall` after edge 4;
- the merged `virr` and empty bitmap after edge 5;
- the new `rvi`, `eval_pend` and any buffered post after edge 6;
- `done` after edge 7.

The bench drives on the falling edge and samples on the falling edge that follows each of those counts. Every check therefore reads a settled value at one exact cycle of the sequence.

// File: rtl/npp_pkg.sv
package npp_pkg;

    localparam int NPP_NVEC  = 256;
    localparam int NPP_AUX_W = 7;
    localparam int NPP_EOI_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_CHECK,
        ST_CLR_ON,
        ST_EOI,
        ST_MERGE,
        ST_RVI,
        ST_EVAL
    } npp_state_e;

    typedef struct packed {
        logic ack;
        logic clr_on;
        logic eoi;
        logic merge;
        logic rvi_upd;
        logic eval;
    } npp_ctl_t;

    function automatic npp_ctl_t npp_decode(input npp_state_e st);
        npp_ctl_t c;
        c         = '0;
        c.ack     = (st == ST_ACK);
        c.clr_on  = (st == ST_CLR_ON);
        c.eoi     = (st == ST_EOI);
        c.merge   = (st == ST_MERGE);
        c.rvi_upd = (st == ST_RVI);
        c.eval    = (st == ST_EVAL);
        return c;
    endfunction

endpackage

// File: rtl/npp_prio_enc.sv
module npp_prio_enc #(
    parameter int N = 256,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] bits,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |bits;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/npp_seq.sv
module npp_seq
    import npp_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_pend,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic [VEC_W-1:0] notif_vec,
    output npp_ctl_t         ctl,
    output logic             vmexit,
    output logic [VEC_W-1:0] exit_vec,
    output logic             done
);
    npp_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic             done_q;
    logic             hit;

    assign hit = (vec_q == notif_vec);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (irq_pend) state_d = ST_ACK;
            ST_ACK:    state_d = ST_CHECK;
            ST_CHECK:  state_d = hit ? ST_CLR_ON : ST_IDLE;
            ST_CLR_ON: state_d = ST_EOI;
            ST_EOI:    state_d = ST_MERGE;
            ST_MERGE:  state_d = ST_RVI;
            ST_RVI:    state_d = ST_EVAL;
            ST_EVAL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ACK) vec_q <= irq_vec;
            done_q <= (state_q == ST_EVAL) || ((state_q == ST_CHECK) && !hit);
        end
    end

    assign ctl      = npp_decode(state_q);
    assign vmexit   = (state_q == ST_CHECK) && !hit;
    assign exit_vec = vec_q;
    assign done     = done_q;

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.ack |=> !ctl.ack);
    // R5
    eoi_after_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.eoi |-> $past(ctl.clr_on));
    // R9
    done_after_eval_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.eval |=> done);
    // R3
    exit_no_eoi_chk: assert property (@(posedge clk) disable iff (rst)
        vmexit |=> (!ctl.eoi && !ctl.clr_on && done));
endmodule

// File: rtl/npp_desc_store.sv
module npp_desc_store #(
    parameter int NVEC  = 256,
    parameter int AUX_W = 7,
    localparam int VEC_W = $clog2(NVEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             post_we,
    input  logic [VEC_W-1:0] post_vec,
    input  logic             aux_we,
    input  logic [AUX_W-1:0] aux_wdata,
    input  logic             clr_on,
    input  logic             lock,
    output logic [NVEC-1:0]  pir,
    output logic             on,
    output logic [AUX_W-1:0] aux
);
    logic [NVEC-1:0]  pir_q;
    logic             on_q;
    logic [AUX_W-1:0] aux_q;
    logic             buf_v;
    logic [VEC_W-1:0] buf_idx;
    logic [NVEC-1:0]  post_mask, buf_mask;
    logic             post_live;

    assign post_live = post_we && !lock;
    assign post_mask = post_live ? (NVEC'(1) << post_vec) : '0;
    assign buf_mask  = buf_v     ? (NVEC'(1) << buf_idx)  : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pir_q   <= '0;
            on_q    <= 1'b0;
            aux_q   <= '0;
            buf_v   <= 1'b0;
            buf_idx <= '0;
        end else begin
            if (lock) pir_q <= '0;
            else      pir_q <= pir_q | post_mask | buf_mask;

            if (lock && post_we) begin
                buf_v   <= 1'b1;
                buf_idx <= post_vec;
            end else if (!lock) begin
                buf_v   <= 1'b0;
            end

            if (post_live || (buf_v && !lock)) on_q <= 1'b1;
            else if (clr_on)                   on_q <= 1'b0;

            if (aux_we) aux_q <= aux_wdata;
        end
    end

    assign pir = pir_q;
    assign on  = on_q;
    assign aux = aux_q;

    // R6
    clear_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
        lock |=> (pir == '0));
    // R7
    park_during_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && post_we) |=> buf_v);
    // R7
    park_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_v && !lock) |=> (pir[$past(buf_idx)] && on));
    // R4
    aux_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_on && !aux_we) |=> $stable(aux));
endmodule

// File: rtl/npp_virt_regs.sv
module npp_virt_regs #(
    parameter int NVEC = 256,
    localparam int VEC_W = $clog2(NVEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             merge,
    input  logic             rvi_upd,
    input  logic [NVEC-1:0]  pir,
    output logic [NVEC-1:0]  virr,
    output logic [VEC_W-1:0] rvi
);
    logic             any_c, any_q;
    logic [VEC_W-1:0] hi_c, hi_q;
    logic [NVEC-1:0]  virr_q;
    logic [VEC_W-1:0] rvi_q;

    npp_prio_enc #(.N(NVEC)) u_enc (
        .bits (pir),
        .any  (any_c),
        .idx  (hi_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            virr_q <= '0;
            rvi_q  <= '0;
            any_q  <= 1'b0;
            hi_q   <= '0;
        end else begin
            if (merge) begin
                virr_q <= virr_q | pir;
                any_q  <= any_c;
                hi_q   <= hi_c;
            end
            if (rvi_upd && any_q && (hi_q > rvi_q)) rvi_q <= hi_q;
        end
    end

    assign virr = virr_q;
    assign rvi  = rvi_q;

    // R8
    rvi_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rvi >= $past(rvi)));
    // R6
    virr_only_on_merge_chk: assert property (@(posedge clk) disable iff (rst)
        !merge |=> (virr == $past(virr)));
endmodule

// File: rtl/notify_post_proc.sv
module notify_post_proc
    import npp_pkg::*;
#(
    parameter int NVEC  = NPP_NVEC,
    parameter int AUX_W = NPP_AUX_W,
    parameter int EOI_W = NPP_EOI_W,
    localparam int VEC_W = $clog2(NVEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_pend,
    input  logic [VEC_W-1:0] irq_vec,
    output logic             irq_ack,
    input  logic [VEC_W-1:0] notif_vec,
    output logic             vmexit,
    output logic [VEC_W-1:0] exit_vec,
    input  logic             post_we,
    input  logic [VEC_W-1:0] post_vec,
    output logic             post_stall,
    input  logic             aux_we,
    input  logic [AUX_W-1:0] aux_wdata,
    output logic [NVEC-1:0]  desc_pir,
    output logic             desc_on,
    output logic [AUX_W-1:0] desc_aux,
    output logic             eoi_wr,
    output logic [EOI_W-1:0] eoi_data,
    output logic [NVEC-1:0]  virr,
    output logic [VEC_W-1:0] rvi,
    output logic             eval_pend,
    output logic             done
);
    npp_ctl_t ctl;

    npp_seq #(.VEC_W(VEC_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .irq_pend  (irq_pend),
        .irq_vec   (irq_vec),
        .notif_vec (notif_vec),
        .ctl       (ctl),
        .vmexit    (vmexit),
        .exit_vec  (exit_vec),
        .done      (done)
    );

    npp_desc_store #(.NVEC(NVEC), .AUX_W(AUX_W)) u_desc (
        .clk       (clk),
        .rst       (rst),
        .post_we   (post_we),
        .post_vec  (post_vec),
        .aux_we    (aux_we),
        .aux_wdata (aux_wdata),
        .clr_on    (ctl.clr_on),
        .lock      (ctl.merge),
        .pir       (desc_pir),
        .on        (desc_on),
        .aux       (desc_aux)
    );

    npp_virt_regs #(.NVEC(NVEC)) u_virt (
        .clk     (clk),
        .rst     (rst),
        .merge   (ctl.merge),
        .rvi_upd (ctl.rvi_upd),
        .pir     (desc_pir),
        .virr    (virr),
        .rvi     (rvi)
    );

    assign irq_ack    = ctl.ack;
    assign post_stall = ctl.merge;
    assign eoi_wr     = ctl.eoi;
    assign eoi_data   = '0;
    assign eval_pend  = ctl.eval;

    // R10
    post_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (post_we && !post_stall) |=> (desc_on && desc_pir[$past(post_vec)]));
    // R7
    stall_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        post_stall |=> !post_stall);
endmodule

// File: tb/tb_notify_post_proc.sv
module tb_notify_post_proc;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         irq_pend = 1'b0;
    logic [7:0]   irq_vec = '0;
    logic         irq_ack;
    logic [7:0]   notif_vec = 8'hF2;
    logic         vmexit;
    logic [7:0]   exit_vec;
    logic         post_we = 1'b0;
    logic [7:0]   post_vec = '0;
    logic         post_stall;
    logic         aux_we = 1'b0;
    logic [6:0]   aux_wdata = '0;
    logic [255:0] desc_pir;
    logic         desc_on;
    logic [6:0]   desc_aux;
    logic         eoi_wr;
    logic [31:0]  eoi_data;
    logic [255:0] virr;
    logic [7:0]   rvi;
    logic         eval_pend;
    logic         done;

    int checks = 0;
    int errors = 0;

    logic [255:0] m_pir  = '0;
    logic         m_on   = 1'b0;
    logic [6:0]   m_aux  = '0;
    logic [255:0] m_virr = '0;
    logic [7:0]   m_rvi  = '0;

    always #2 clk = ~clk;

    notify_post_proc dut (
        .clk(clk), .rst(rst), .irq_pend(irq_pend), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .notif_vec(notif_vec), .vmexit(vmexit),
        .exit_vec(exit_vec), .post_we(post_we), .post_vec(post_vec),
        .post_stall(post_stall), .aux_we(aux_we), .aux_wdata(aux_wdata),
        .desc_pir(desc_pir), .desc_on(desc_on), .desc_aux(desc_aux),
        .eoi_wr(eoi_wr), .eoi_data(eoi_data), .virr(virr), .rvi(rvi),
        .eval_pend(eval_pend), .done(done)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic logic [7:0] top_idx(input logic [255:0] b);
        logic [7:0] h = '0;
        for (int i = 0; i < 256; i++) if (b[i]) h = 8'(i);
        return h;
    endfunction

    function automatic logic [7:0] next_rvi(input logic [7:0] old, input logic [255:0] b);
        if (b == '0) return old;
        return (top_idx(b) > old) ? top_idx(b) : old;
    endfunction

    task automatic post(input logic [7:0] v);
        post_we = 1'b1; post_vec = v;
        tick();
        post_we = 1'b0;
        m_pir[v] = 1'b1; m_on = 1'b1;
        check("R10 post bitmap", desc_pir, m_pir);
        check("R10 post flag", {255'd0, desc_on}, {255'd0, 1'b1});
    endtask

    task automatic write_aux(input logic [6:0] a);
        aux_we = 1'b1; aux_wdata = a;
        tick();
        aux_we = 1'b0;
        m_aux = a;
    endtask

    task automatic run_event(input logic [7:0] vec, input bit inj_clr, input logic [7:0] p1,
                             input bit inj_merge, input logic [7:0] p2);
        logic [255:0] exp_virr;
        logic [7:0]   exp_rvi;
        irq_pend = 1'b1; irq_vec = vec;
        tick();                                   // after edge 0: ACK
        check("R2 ack", {255'd0, irq_ack}, {255'd0, 1'b1});
        tick();                                   // after edge 1: CHECK
        irq_pend = 1'b0;
        check("R2 ack single", {255'd0, irq_ack}, '0);
        if (vec != notif_vec) begin
            check("R3 vmexit", {255'd0, vmexit}, {255'd0, 1'b1});
            check("R3 exit vector", {248'd0, exit_vec}, {248'd0, vec});
            tick();                               // after edge 2: IDLE
            check("R3 no eoi", {255'd0, eoi_wr}, '0);
            check("R9 done mismatch", {255'd0, done}, {255'd0, 1'b1});
            check("R3 bitmap kept", desc_pir, m_pir);
            check("R3 virr kept", virr, m_virr);
            check("R3 rvi kept", {248'd0, rvi}, {248'd0, m_rvi});
            return;
        end
        check("R3 no vmexit on match", {255'd0, vmexit}, '0);
        tick();                                   // after edge 2: CLR_ON
        if (inj_clr) begin post_we = 1'b1; post_vec = p1; end
        tick();                                   // after edge 3: EOI
        post_we = 1'b0;
        if (inj_clr) m_pir[p1] = 1'b1;
        m_on = inj_clr;
        check(inj_clr ? "R10 flag kept by concurrent post" : "R4 flag cleared",
              {255'd0, desc_on}, {255'd0, m_on});
        check("R4 aux kept", {249'd0, desc_aux}, {249'd0, m_aux});
        check("R5 eoi strobe", {255'd0, eoi_wr}, {255'd0, 1'b1});
        check("R5 eoi data", {224'd0, eoi_data}, '0);
        tick();                                   // after edge 4: MERGE
        check("R5 eoi single", {255'd0, eoi_wr}, '0);
        check("R7 stall", {255'd0, post_stall}, {255'd0, 1'b1});
        if (inj_merge) begin post_we = 1'b1; post_vec = p2; end
        exp_virr = m_virr | m_pir;
        exp_rvi  = next_rvi(m_rvi, m_pir);
        tick();                                   // after edge 5: RVI
        post_we = 1'b0;
        check("R6 bitmap cleared", desc_pir, '0);
        check("R6 virr merged", virr, exp_virr);
        check("R7 stall released", {255'd0, post_stall}, '0);
        m_pir = '0; m_virr = exp_virr;
        tick();                                   // after edge 6: EVAL
        check("R8 rvi", {248'd0, rvi}, {248'd0, exp_rvi});
        check("R9 eval", {255'd0, eval_pend}, {255'd0, 1'b1});
        m_rvi = exp_rvi;
        if (inj_merge) begin
            m_pir[p2] = 1'b1; m_on = 1'b1;
            check("R7 parked post lands", desc_pir, m_pir);
            check("R7 parked post flag", {255'd0, desc_on}, {255'd0, 1'b1});
            check("R7 parked post not merged", virr, m_virr);
        end
        tick();                                   // after edge 7: IDLE
        check("R9 done", {255'd0, done}, {255'd0, 1'b1});
        check("R9 eval single", {255'd0, eval_pend}, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst = 1'b0;
        check("R1 reset virr", virr, '0);
        check("R1 reset rvi", {248'd0, rvi}, '0);
        check("R1 reset stall/done/eval", {253'd0, post_stall, done, eval_pend}, '0);
        check("R1 reset descriptor", desc_pir, '0);
        check("R1 reset flag", {255'd0, desc_on}, '0);
        tick();

        // directed: empty bitmap keeps RVI at zero
        run_event(notif_vec, 1'b0, 8'd0, 1'b0, 8'd0);
        // directed: only index 0
        post(8'd0);
        run_event(notif_vec, 1'b0, 8'd0, 1'b0, 8'd0);
        // directed: top index 255 with aux bits set
        write_aux(7'h55);
        post(8'd255); post(8'd17);
        run_event(notif_vec, 1'b0, 8'd0, 1'b0, 8'd0);
        // directed: lower index than RVI does not lower it
        post(8'd40);
        run_event(notif_vec, 1'b0, 8'd0, 1'b0, 8'd0);
        // directed: empty bitmap with nonzero RVI
        run_event(notif_vec, 1'b0, 8'd0, 1'b0, 8'd0);
        // directed: mismatch
        post(8'd99);
        run_event(8'h31, 1'b0, 8'd0, 1'b0, 8'd0);
        // directed: post during flag clear and during merge
        run_event(notif_vec, 1'b1, 8'd120, 1'b1, 8'd200);
        run_event(notif_vec, 1'b0, 8'd0, 1'b0, 8'd0);

        // reset mid-run clears state
        post(8'd7);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        m_pir = '0; m_on = 1'b0; m_aux = '0; m_virr = '0; m_rvi = '0;
        check("R1 mid reset virr", virr, '0);
        check("R1 mid reset rvi", {248'd0, rvi}, '0);
        check("R1 mid reset bitmap", desc_pir, '0);
        tick();

        for (int it = 0; it < 60; it++) begin
            int nposts = $urandom_range(0, 4);
            logic [7:0] v;
            if ($urandom_range(0, 5) == 0) notif_vec = 8'($urandom);
            if ($urandom_range(0, 3) == 0) write_aux(7'($urandom));
            for (int k = 0; k < nposts; k++) post(8'($urandom));
            v = ($urandom_range(0, 9) < 7) ? notif_vec : 8'($urandom);
            run_event(v, 1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
            check("R10 flag model", {255'd0, desc_on}, {255'd0, m_on});
            check("R4 aux model", {249'd0, desc_aux}, {249'd0, m_aux});
        end

        report();
        $finish;
    end
endmodule